// File: doc/BRIEF.md
# Pipelined Data Bus Arbiter

This block hands out the data bus of a split-transaction shared bus whose address phases run ahead of their data phases. Each accepted address phase is pushed into a four-entry in-order queue with three tags: the master it belongs to, whether the master or the memory drives its data, and a size code. Snoop responses arrive later, in the same order as the pushes. A response either clears an entry for data transfer or retries it. A retried entry leaves the queue without ever receiving the bus.

The arbiter gives the oldest cleared entry a one-cycle, one-hot data grant. It then counts transfer acknowledges until the tenure's final beat, which it flags. The next tenure may follow with no gap only when the same device drives data in both tenures and the finishing tenure had more than one beat. In that case the next grant is issued in the same cycle as the final acknowledge. In every other case a turnaround cycle separates the tenures, and a debug counter records each forced turnaround.

Top module: `data_bus_arb`

## Requirements
- R1: While rst_n is low, dbg and data_last are zero, at_full is low and dead_cnt is zero; the queue is empty when reset is released.
- R2: The size code gives the beat count of a tenure: 0 is one beat, 1 is two beats, 2 is four beats, 3 is one beat. data_last is high in the cycle of the tenure's final acknowledge, counting only acknowledges from the cycle after its grant.
- R3: An acknowledge (ta) while no tenure is active has no effect: data_last stays low and later beat counting is unchanged.
- R4: dbg is one-hot with bit at_master of the granted entry, high for exactly one cycle per tenure. Tenures are granted in push order.
- R5: An entry is granted only after its own snoop response without retry. Responses resolve the oldest unresolved entry in order. A response while no entry is unresolved is ignored.
- R6: An entry whose response has snp_retry high is removed and never granted; the entries behind it are still granted in order.
- R7: If the next entry's data comes from the same driver and the current tenure has two or more beats, its grant is issued in the cycle of the current final acknowledge. Memory counts as one driver; a master-driven tenure counts as that master's.
- R8: If the driver differs, no grant is issued in the final-acknowledge cycle. The earliest grant is the following cycle, which leaves one dead cycle on the data bus.
- R9: After a single-beat tenure no grant is issued in its acknowledge cycle; the earliest grant is the next cycle.
- R10: A multi-beat tenure may stream straight into a single-beat tenure from the same driver.
- R11: at_full is high while four entries are queued, and a push then is ignored.
- R12: dead_cnt (CW bits, wrapping) increases by one at each final acknowledge at which the oldest entry is cleared for grant but may not stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| at_push | input | 1 | Push an address phase into the queue |
| at_master | input | MW | Master id of the pushed phase (below NM) |
| at_src | input | 1 | Data driver: 0 master, 1 memory |
| at_size | input | 2 | Size code (see R2) |
| at_full | output | 1 | Queue holds DEPTH entries |
| snp_valid | input | 1 | Snoop response for the oldest unresolved entry |
| snp_retry | input | 1 | The response retries that entry |
| ta | input | 1 | Transfer acknowledge for one data beat |
| dbg | output | NM | One-hot data bus grant |
| data_last | output | 1 | Final acknowledge of the active tenure |
| dead_cnt | output | CW | Forced turnaround count |

## Verification
The bench aims at the cycle of a final acknowledge. It covers a memory-to-master change of driver, a switch between masters, a single-beat tenure followed by a same-driver tenure, and multi-beat into single-beat. An arbiter that streamed in any forbidden case would grant one cycle early. One that refused a legal stream would grant one cycle late and raise dead_cnt. A retried entry is placed ahead of a cleared one, so a queue that granted killed entries or stalled behind them shows a wrong grant vector. A fifth push into a full queue would otherwise turn into an extra grant later. Stray acknowledges on an idle bus are also applied, and an arbiter that counted them would end the next tenure early.

// File: rtl/dba_pkg.sv
package dba_pkg;
  localparam int MAX_BEATS = 4;
  localparam int BCW = $clog2(MAX_BEATS + 1);
  localparam logic SRC_MEM = 1'b1;

  function automatic logic [BCW-1:0] size_to_beats(input logic [1:0] sz);
    case (sz)
      2'd1:    size_to_beats = BCW'(2);
      2'd2:    size_to_beats = BCW'(4);
      default: size_to_beats = BCW'(1);
    endcase
  endfunction
endpackage

// File: rtl/dba_queue.sv
module dba_queue import dba_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int MW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_en,
  input  logic [MW-1:0]  push_master,
  input  logic           push_src,
  input  logic [BCW-1:0] push_beats,
  input  logic           snp_valid,
  input  logic           snp_retry,
  input  logic           pop,
  output logic           head_valid,
  output logic           head_resolved,
  output logic           head_killed,
  output logic [MW-1:0]  head_master,
  output logic           head_src,
  output logic [BCW-1:0] head_beats,
  output logic           full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d, sn_q, sn_d, used;
  logic [DEPTH-1:0] res_q, res_d, kil_q, kil_d;
  logic [MW-1:0]    mst_q [DEPTH];
  logic             src_q [DEPTH];
  logic [BCW-1:0]   bts_q [DEPTH];
  logic             push_ok, snp_ok, pop_ok;

  assign used    = wr_q - rd_q;
  assign full    = (used == PW'(DEPTH));
  assign push_ok = push_en && !full;
  assign snp_ok  = snp_valid && (sn_q != wr_q);
  assign pop_ok  = pop && (used != '0);

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    sn_d  = sn_q;
    res_d = res_q;
    kil_d = kil_q;
    if (pop_ok) begin
      res_d[rd_q[AW-1:0]] = 1'b0;
      kil_d[rd_q[AW-1:0]] = 1'b0;
      rd_d = rd_q + PW'(1);
    end
    if (snp_ok) begin
      res_d[sn_q[AW-1:0]] = 1'b1;
      kil_d[sn_q[AW-1:0]] = snp_retry;
      sn_d = sn_q + PW'(1);
    end
    if (push_ok) wr_d = wr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      sn_q  <= '0;
      res_q <= '0;
      kil_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      sn_q  <= sn_d;
      res_q <= res_d;
      kil_q <= kil_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mst_q[wr_q[AW-1:0]] <= push_master;
      src_q[wr_q[AW-1:0]] <= push_src;
      bts_q[wr_q[AW-1:0]] <= push_beats;
    end
  end

  assign head_valid    = (used != '0);
  assign head_resolved = res_q[rd_q[AW-1:0]];
  assign head_killed   = kil_q[rd_q[AW-1:0]];
  assign head_master   = mst_q[rd_q[AW-1:0]];
  assign head_src      = src_q[rd_q[AW-1:0]];
  assign head_beats    = bts_q[rd_q[AW-1:0]];
endmodule

// File: rtl/dba_tracker.sv
module dba_tracker import dba_pkg::*; #(
  parameter int MW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [BCW-1:0] load_beats,
  input  logic           load_src,
  input  logic [MW-1:0]  load_master,
  input  logic           ta,
  output logic           busy,
  output logic           last,
  output logic           cur_multi,
  output logic           cur_src,
  output logic [MW-1:0]  cur_master
);
  logic           busy_q, busy_d;
  logic [BCW-1:0] left_q, left_d;

  assign busy = busy_q;
  assign last = busy_q && ta && (left_q == BCW'(1));

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    if (load) begin
      busy_d = 1'b1;
      left_d = load_beats;
    end else if (last) begin
      busy_d = 1'b0;
      left_d = '0;
    end else if (busy_q && ta) begin
      left_d = left_q - BCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      cur_multi  <= (load_beats > BCW'(1));
      cur_src    <= load_src;
      cur_master <= load_master;
    end
  end
endmodule

// File: rtl/data_bus_arb.sv
module data_bus_arb import dba_pkg::*; #(
  parameter int NM = 4,
  parameter int DEPTH = 4,
  parameter int CW = 8,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_push,
  input  logic [MW-1:0] at_master,
  input  logic          at_src,
  input  logic [1:0]    at_size,
  output logic          at_full,
  input  logic          snp_valid,
  input  logic          snp_retry,
  input  logic          ta,
  output logic [NM-1:0] dbg,
  output logic          data_last,
  output logic [CW-1:0] dead_cnt
);
  logic           h_valid, h_res, h_kill, h_src, pop;
  logic [MW-1:0]  h_master;
  logic [BCW-1:0] h_beats;
  logic           busy, last, cur_multi, cur_src;
  logic [MW-1:0]  cur_master;
  logic           head_ok, same_drv, stream_ok, grant_fire, drop;
  logic [CW-1:0]  dead_q, dead_d;

  dba_queue #(.DEPTH(DEPTH), .MW(MW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_en(at_push), .push_master(at_master), .push_src(at_src),
    .push_beats(size_to_beats(at_size)),
    .snp_valid(snp_valid), .snp_retry(snp_retry), .pop(pop),
    .head_valid(h_valid), .head_resolved(h_res), .head_killed(h_kill),
    .head_master(h_master), .head_src(h_src), .head_beats(h_beats),
    .full(at_full)
  );

  dba_tracker #(.MW(MW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .load(grant_fire), .load_beats(h_beats), .load_src(h_src),
    .load_master(h_master), .ta(ta),
    .busy(busy), .last(last), .cur_multi(cur_multi),
    .cur_src(cur_src), .cur_master(cur_master)
  );

  assign head_ok    = h_valid && h_res && !h_kill;
  assign drop       = h_valid && h_res && h_kill;
  assign same_drv   = (cur_src == h_src) && ((h_src == SRC_MEM) || (cur_master == h_master));
  assign stream_ok  = last && cur_multi && same_drv;
  assign grant_fire = head_ok && (!busy || stream_ok);
  assign pop        = grant_fire || drop;
  assign data_last  = last;

  always_comb begin
    dbg = '0;
    if (grant_fire) dbg[h_master] = 1'b1;
  end

  always_comb begin
    dead_d = dead_q;
    if (last && head_ok && !stream_ok) dead_d = dead_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dead_q <= '0;
    else        dead_q <= dead_d;
  end

  assign dead_cnt = dead_q;
endmodule

// File: rtl/data_bus_arb_chk.sv
module data_bus_arb_chk #(
  parameter int NM = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] dbg,
  input logic          busy,
  input logic          last,
  input logic          cur_multi,
  input logic          at_full,
  input logic          pop,
  input logic [CW-1:0] dead_cnt
);
  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbg));

  p_busy_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg != '0) |=> busy);

  p_grant_free_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg != '0) |-> (!busy || last));

  p_no_stream_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !cur_multi) |-> (dbg == '0));

  p_last_frees_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (dbg == '0)) |=> !busy);

  p_full_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && !pop) |=> at_full);

  p_dead_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(dead_cnt - $past(dead_cnt)) <= CW'(1)));
endmodule

bind data_bus_arb data_bus_arb_chk #(.NM(NM), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg(dbg), .busy(busy), .last(last),
  .cur_multi(cur_multi), .at_full(at_full), .pop(pop), .dead_cnt(dead_cnt)
);

// File: tb/data_bus_arb_tb.sv
module data_bus_arb_tb;
  localparam int PERIOD = 10;
  localparam int NM = 4;
  localparam int CW = 8;

  logic clk, rst_n, at_push, at_src, at_full, snp_valid, snp_retry, ta, data_last;
  logic [1:0] at_master, at_size;
  logic [NM-1:0] dbg;
  logic [CW-1:0] dead_cnt;

  int n_chk, n_fail;
  bit done;

  int q_m [4], q_s [4], q_b [4];
  bit q_res [4], q_kil [4];
  int rd, wr, sn, left, cmast, dead;
  bit busy, cmulti, csrc;

  data_bus_arb #(.NM(NM), .DEPTH(4), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .at_push(at_push), .at_master(at_master),
    .at_src(at_src), .at_size(at_size), .at_full(at_full),
    .snp_valid(snp_valid), .snp_retry(snp_retry), .ta(ta),
    .dbg(dbg), .data_last(data_last), .dead_cnt(dead_cnt)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic int beats_of(input int sz);
    if (sz == 1) return 2;
    if (sz == 2) return 4;
    return 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit p, input int m, input bit s,
                      input int sz, input bit sv, input bit rt, input bit t);
    int h, cnt, edbg;
    bit hv, hok, drop, last, same, strm, fire, full;
    @(negedge clk);
    at_push = p; at_master = 2'(m); at_src = s; at_size = 2'(sz);
    snp_valid = sv; snp_retry = rt; ta = t;
    #1;
    cnt  = wr - rd;
    full = (cnt == 4);
    h    = rd % 4;
    hv   = (cnt > 0);
    hok  = hv && q_res[h] && !q_kil[h];
    drop = hv && q_res[h] && q_kil[h];
    last = busy && t && (left == 1);
    same = (csrc == q_s[h][0]) && (q_s[h] == 1 || cmast == q_m[h]);
    strm = last && cmulti && same;
    fire = hok && (!busy || strm);
    edbg = fire ? (1 << q_m[h]) : 0;
    chk(tag, int'(dbg), edbg);
    chk("R2 R3", int'(data_last), int'(last));
    chk("R11", int'(at_full), int'(full));
    chk("R12", int'(dead_cnt), dead % 256);
    if (last && hok && !strm) dead++;
    if (fire) begin
      busy = 1; left = q_b[h]; cmulti = (q_b[h] > 1); csrc = q_s[h][0]; cmast = q_m[h];
    end else if (last) begin
      busy = 0; left = 0;
    end else if (busy && t) left--;
    if (fire || drop) begin q_res[h] = 0; q_kil[h] = 0; rd++; end
    if (sv && sn != wr) begin q_res[sn % 4] = 1; q_kil[sn % 4] = rt; sn++; end
    if (p && !full) begin
      q_m[wr % 4] = m; q_s[wr % 4] = s; q_b[wr % 4] = beats_of(sz); wr++;
    end
  endtask

  task automatic idle(input string tag, input bit t);
    step(tag, 0, 0, 0, 0, 0, 0, t);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    n_chk = 0; n_fail = 0;
    rd = 0; wr = 0; sn = 0; left = 0; cmast = 0; dead = 0;
    busy = 0; cmulti = 0; csrc = 0;
    for (int i = 0; i < 4; i++) begin q_res[i] = 0; q_kil[i] = 0; q_m[i] = 0; q_s[i] = 0; q_b[i] = 1; end
    rst_n = 1'b0;
    at_push = 0; at_master = 0; at_src = 0; at_size = 0;
    snp_valid = 0; snp_retry = 0; ta = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    at_push = 1; snp_valid = 1; ta = 1;
    #1;
    chk("R1", int'(dbg), 0);
    chk("R1", int'(data_last), 0);
    chk("R1", int'(at_full), 0);
    chk("R1", int'(dead_cnt), 0);
    at_push = 0; snp_valid = 0; ta = 0;
    rst_n = 1'b1;

    idle("R3", 1); idle("R3", 1);
    step("R5", 1, 1, 0, 2, 0, 0, 0);
    step("R5", 1, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 0, 0);
    step("R4", 1, 1, 0, 2, 1, 0, 0);
    step("R2", 1, 2, 1, 2, 1, 0, 1);
    step("R2", 0, 0, 0, 0, 1, 0, 1);
    idle("R2", 1);
    idle("R10", 1);
    idle("R9", 1);
    idle("R9", 0);
    for (int i = 0; i < 3; i++) idle("R2", 1);
    idle("R8", 1);
    idle("R8", 0);
    step("R7", 1, 3, 1, 2, 0, 0, 1);
    step("R7", 1, 0, 0, 0, 1, 0, 1);
    step("R6", 1, 2, 0, 1, 1, 1, 1);
    step("R7", 0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 8; i++) idle("R6", 1);
    for (int i = 0; i < 5; i++) step("R11", 1, i % 4, 0, 3, 0, 0, 0);
    idle("R11", 0);
    for (int i = 0; i < 6; i++) step("R5", 0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 6; i++) idle("R3", 1);

    for (int i = 0; i < 4000; i++) begin
      step("R4", ($urandom % 3) == 0, int'($urandom % 4), 1'($urandom % 2),
           int'($urandom % 4), ($urandom % 3) == 0, ($urandom % 4) == 0,
           ($urandom % 4) != 0);
    end
    for (int i = 0; i < 40; i++) step("R4", 0, 0, 0, 0, 1, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule